// File: doc/BRIEF.md
# Dual-CPU Interrupt Router

This block is a small bank of byte-wide control registers that decides which of two processors, a primary CPU or a coprocessor, receives interrupts. When the coprocessor is the interrupt master, every new interrupt level from the primary side arrives with an update strobe. The level is stored inverted in an emulation register and compared against a coprocessor mask. The coprocessor interrupt line follows the result of that comparison. When the primary CPU is the master, the block instead scans a register of pending levels against the coprocessor mask and raises the coprocessor line when a pending level reaches it.

All fields are active low. Software changes bits with set/clear writes: bit 7 of the write data chooses between setting and clearing, and bits 6:0 select the bits that are affected. Three register offsets are decoded. Every other offset in the byte address space is reserved. The coprocessor interrupt output is registered.

Top module: `dual_irq_router`

## Requirements
- R1: After reset, the control register (offset 0x28) reads 0x50, the emulation register (offset 0x30) reads 0x3F, the level register (offset 0x38) reads 0x7F, and coIrq is 0.
- R2: A decoded write with wdata[7]=1 sets the register bits selected by wdata[6:0]. A decoded write with wdata[7]=0 clears those bits. The new value is readable from the next cycle on.
- R3: Read bit 7 is always 0. In the control register, read bits 6 and 4 are always 1, whatever was written. Control bit 0 = 1 makes the primary CPU the master. Control bit 1 = 0 enables emulation.
- R4: Offsets other than 0x28, 0x30 and 0x38 read 0. Writes to them change no register and do not affect coIrq.
- R5: Primary-master mode holds when control bit 0 = 1, control bit 1 = 0 and emulation bit 6 = 0. In this mode coIrq is 1 one cycle after the registers settle if and only if, with mask = ~emul[2:0], mask < 7 and some bit i >= mask of ~level[6:0] is 1. Here level bit i stands for interrupt level i+1.
- R6: In primary-master mode, a decoded mask of 7 (emul[2:0] = 000) never asserts coIrq.
- R7: Coprocessor-master mode holds when control bit 0 = 0, control bit 1 = 0 and emulation bit 6 = 0. In this mode a level strobe writes ~level into emul[5:3] and sets coIrq, at the same edge, to (level > ~emul[2:0]).
- R8: The level input is 4-bit two's complement. Negative values are treated as level 0.
- R9: A strobe outside coprocessor-master mode leaves emul[5:3] and coIrq unchanged.
- R10: Outside primary-master mode, a decoded register write drives coIrq to 0 at the following edge, unless a strobe is accepted at that edge.
- R11: A strobe in the same cycle as a decoded write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte offset of the register |
| regWdata | input | 8 | Write data: bit 7 selects set or clear, bits 6:0 select the bits |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| priLevelStb | input | 1 | Strobe for a new primary interrupt level |
| priLevel | input | 4 | New primary level, two's complement |
| coIrq | output | 1 | Level-sensitive coprocessor interrupt request |

## Verification
The bench goes after three kinds of corner case.

- **Level-scan boundary.** The pending level sits exactly at the mask, and the mask is 7. A design with an off-by-one comparison would raise the line one level too early or too late, or would fire with a full mask.
- **Strobe handling.** Negative level values must clamp to 0; without the clamp they wrap into high levels and falsely interrupt. A strobe that collides with a register write must be dropped, and a strobe in the wrong mode must be ignored. A design that gets either wrong corrupts the stored level field.
- **Write-driven deassertion outside primary-master mode.** A design that skips this leaves a stale interrupt asserted after delivery has been disabled.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_EMU  = 2'd2,
    SEL_LVL  = 2'd3
  } regSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrCtl;
    logic       wrEmu;
    logic       wrLvl;
    logic       setMode;
    logic [6:0] bitSel;
    logic       stbTake;
    logic       wrSeen;
    regSel_t    rdSel;
  } ctlStb_t;

  function automatic logic [6:0] applySetClr(input logic [6:0] cur,
                                             input logic setMode,
                                             input logic [6:0] bitSel);
    return setMode ? (cur | bitSel) : (cur & ~bitSel);
  endfunction

endpackage

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CTL_OFS = 'h28,
  parameter int EMU_OFS = 'h30,
  parameter int LVL_OFS = 'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              priLevelStb,
  input  logic              modeB,
  output ctlStb_t           stb
);

  regSel_t sel;
  logic    anyWr;
  logic    wrSeenQ;

  always_comb begin
    if (regAddr == ADDR_W'(CTL_OFS))      sel = SEL_CTL;
    else if (regAddr == ADDR_W'(EMU_OFS)) sel = SEL_EMU;
    else if (regAddr == ADDR_W'(LVL_OFS)) sel = SEL_LVL;
    else                                  sel = SEL_NONE;
  end

  assign anyWr = regWr && (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrSeenQ <= 1'b0;
    else       wrSeenQ <= anyWr;
  end

  always_comb begin
    stb.wrCtl   = regWr && (sel == SEL_CTL);
    stb.wrEmu   = regWr && (sel == SEL_EMU);
    stb.wrLvl   = regWr && (sel == SEL_LVL);
    stb.setMode = regWdata[7];
    stb.bitSel  = regWdata[6:0];
    stb.stbTake = priLevelStb && modeB && !anyWr;
    stb.wrSeen  = wrSeenQ;
    stb.rdSel   = sel;
  end

  // R4
  onehot_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtl, stb.wrEmu, stb.wrLvl}));

  // R11
  stb_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && sel != SEL_NONE) |-> !stb.stbTake);

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStb_t    stb,
  input  logic [3:0] priLevel,
  output logic [7:0] regRdata,
  output logic       modeB,
  output logic       coIrq
);

  localparam int NLVL = 7;
  localparam logic [6:0] CTL_RST = 7'h00;
  localparam logic [6:0] EMU_RST = 7'h3F;
  localparam logic [6:0] LVL_RST = 7'h7F;
  localparam logic [6:0] CTL_ONES = 7'h50;

  logic [6:0] ctlQ, emuQ, lvlQ;
  logic       irqQ;
  logic       modeA;
  logic [2:0] maskDec;
  logic [2:0] lvlClamp;
  logic [NLVL-1:0] pendVec, hitVec;
  logic       scanHit;
  logic       irqNext;
  logic       delivOn;

  assign delivOn  = !ctlQ[1] && !emuQ[6];
  assign modeA    = ctlQ[0] && delivOn;
  assign modeB    = !ctlQ[0] && delivOn;
  assign maskDec  = ~emuQ[2:0];
  assign lvlClamp = priLevel[3] ? 3'd0 : priLevel[2:0];
  assign pendVec  = ~lvlQ;

  for (genvar i = 0; i < NLVL; i++) begin : gScan
    assign hitVec[i] = pendVec[i] && (3'(i) >= maskDec);
  end

  assign scanHit = (maskDec != 3'd7) && (|hitVec);

  always_comb begin
    if (modeA)            irqNext = scanHit;
    else if (stb.stbTake) irqNext = (lvlClamp > maskDec);
    else if (stb.wrSeen)  irqNext = 1'b0;
    else                  irqNext = irqQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= CTL_RST;
      emuQ <= EMU_RST;
      lvlQ <= LVL_RST;
      irqQ <= 1'b0;
    end else begin
      irqQ <= irqNext;
      if (stb.wrCtl) ctlQ <= applySetClr(ctlQ, stb.setMode, stb.bitSel);
      if (stb.wrLvl) lvlQ <= applySetClr(lvlQ, stb.setMode, stb.bitSel);
      if (stb.wrEmu)
        emuQ <= applySetClr(emuQ, stb.setMode, stb.bitSel);
      else if (stb.stbTake)
        emuQ[5:3] <= ~lvlClamp;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_CTL: regRdata = {1'b0, ctlQ | CTL_ONES};
      SEL_EMU: regRdata = {1'b0, emuQ};
      SEL_LVL: regRdata = {1'b0, lvlQ};
      default: regRdata = 8'h00;
    endcase
  end

  assign coIrq = irqQ;

  // R6
  full_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeA && emuQ[2:0] == 3'b000) |=> !coIrq);

  // R10
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSeen && !modeA && !stb.stbTake) |=> !coIrq);

  // R9
  stb_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeB && !stb.wrEmu) |=> $stable(emuQ[5:3]));

  // R7
  stb_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stbTake |=> (emuQ[5:3] == ~$past(lvlClamp)));

endmodule

// File: rtl/dual_irq_router.sv
module dual_irq_router
  import irq_route_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CTL_OFS = 'h28,
  parameter int EMU_OFS = 'h30,
  parameter int LVL_OFS = 'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              priLevelStb,
  input  logic [3:0]        priLevel,
  output logic              coIrq
);

  ctlStb_t stb;
  logic    modeB;

  irq_route_ctl #(
    .ADDR_W (ADDR_W),
    .CTL_OFS(CTL_OFS),
    .EMU_OFS(EMU_OFS),
    .LVL_OFS(LVL_OFS)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .priLevelStb(priLevelStb),
    .modeB      (modeB),
    .stb        (stb)
  );

  irq_route_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .priLevel(priLevel),
    .regRdata(regRdata),
    .modeB   (modeB),
    .coIrq   (coIrq)
  );

  // R3
  const_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(CTL_OFS)) |-> (regRdata[6] && regRdata[4] && !regRdata[7]));

endmodule

// File: tb/dual_irq_router_bench.sv
`timescale 1ns/1ps
module dual_irq_router_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       priLevelStb = 1'b0;
  logic [3:0] priLevel = '0;
  logic       coIrq;

  int checks = 0;
  int errors = 0;

  logic [6:0] mCtl, mEmu, mLvl;
  bit mIrq, mWrSeen;

  always #5 clk = ~clk;

  dual_irq_router u_dual_irq_router (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .priLevelStb(priLevelStb),
    .priLevel(priLevel), .coIrq(coIrq)
  );

  function automatic bit isDec(logic [5:0] a);
    return (a == 6'h28) || (a == 6'h30) || (a == 6'h38);
  endfunction

  function automatic bit mModeA();
    return mCtl[0] && !mCtl[1] && !mEmu[6];
  endfunction

  function automatic bit mModeB();
    return !mCtl[0] && !mCtl[1] && !mEmu[6];
  endfunction

  function automatic bit mScan();
    logic [2:0] msk = ~mEmu[2:0];
    bit hit = 0;
    if (msk == 3'd7) return 0;
    for (int i = 0; i < 7; i++)
      if (!mLvl[i] && i >= int'(msk)) hit = 1;
    return hit;
  endfunction

  function automatic logic [7:0] mRead(logic [5:0] a);
    case (a)
      6'h28:   return {1'b0, mCtl | 7'h50};
      6'h30:   return {1'b0, mEmu};
      6'h38:   return {1'b0, mLvl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic mUpdate(bit wr, logic [5:0] a, logic [7:0] d, bit s, logic [3:0] l);
    bit dec = wr && isDec(a);
    bit take = s && mModeB() && !dec;
    logic [2:0] cl = l[3] ? 3'd0 : l[2:0];
    logic [2:0] msk = ~mEmu[2:0];
    bit nIrq;
    if (mModeA())     nIrq = mScan();
    else if (take)    nIrq = (cl > msk);
    else if (mWrSeen) nIrq = 0;
    else              nIrq = mIrq;
    if (dec) begin
      case (a)
        6'h28: mCtl = d[7] ? (mCtl | d[6:0]) : (mCtl & ~d[6:0]);
        6'h30: mEmu = d[7] ? (mEmu | d[6:0]) : (mEmu & ~d[6:0]);
        default: mLvl = d[7] ? (mLvl | d[6:0]) : (mLvl & ~d[6:0]);
      endcase
    end
    if (take) mEmu[5:3] = ~cl;
    mWrSeen = dec;
    mIrq = nIrq;
  endtask

  task automatic step(bit wr, logic [5:0] a, logic [7:0] d, bit s, logic [3:0] l, string tag);
    @(negedge clk);
    chk(coIrq == mIrq, tag, "coIrq", coIrq, mIrq);
    regWr = wr; regAddr = a; regWdata = d; priLevelStb = s; priLevel = l;
    #1;
    chk(regRdata == mRead(a), tag, "regRdata", regRdata, mRead(a));
    @(posedge clk);
    mUpdate(wr, a, d, s, l);
  endtask

  task automatic idle(logic [5:0] a, string tag);
    step(0, a, 8'h00, 0, 4'h0, tag);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d, string tag);
    step(1, a, d, 0, 4'h0, tag);
    idle(a, tag);
    idle(a, tag);
  endtask

  task automatic strobe(logic [3:0] l, string tag);
    step(0, 6'h30, 8'h00, 1, l, tag);
    idle(6'h30, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mCtl = 7'h00; mEmu = 7'h3F; mLvl = 7'h7F; mIrq = 0; mWrSeen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values, R3 constant bits
    idle(6'h28, "R1"); idle(6'h30, "R1"); idle(6'h38, "R1");
    wr(6'h28, 8'h00, "R3"); wr(6'h28, 8'h80, "R3");
    // R2 set/clear
    wr(6'h38, 8'h05, "R2"); wr(6'h38, 8'h81, "R2");
    // R4 reserved offsets
    wr(6'h08, 8'hFF, "R4"); idle(6'h38, "R4"); idle(6'h3F, "R4");
    // R7 coprocessor-master strobe
    strobe(4'd3, "R7"); idle(6'h30, "R7");
    // R8 negative clamps to 0
    strobe(4'hE, "R8"); idle(6'h30, "R8");
    strobe(4'd3, "R7");
    strobe(4'h8, "R8");
    wr(6'h30, 8'h02, "R7");
    strobe(4'd2, "R7"); strobe(4'd3, "R7");
    // R10 write clears irq outside primary-master
    wr(6'h38, 8'h80, "R10");
    strobe(4'd6, "R10");
    wr(6'h30, 8'hC0, "R10"); wr(6'h30, 8'h40, "R10");
    // R11 write and strobe together
    step(1, 6'h38, 8'h80, 1, 4'd7, "R11"); idle(6'h30, "R11"); idle(6'h30, "R11");
    // R5 primary-master scan
    wr(6'h28, 8'h81, "R5");
    wr(6'h38, 8'h08, "R5");
    // R6 mask of 7
    wr(6'h30, 8'h07, "R6");
    wr(6'h38, 8'h40, "R6");
    wr(6'h30, 8'h87, "R5"); wr(6'h30, 8'h05, "R5");
    wr(6'h38, 8'hC8, "R5"); wr(6'h38, 8'h40, "R5");
    wr(6'h30, 8'hC0, "R5"); wr(6'h30, 8'h40, "R5");
    // R9 strobe ignored outside coprocessor-master
    strobe(4'd7, "R9"); idle(6'h30, "R9");
    wr(6'h28, 8'h01, "R9");
    wr(6'h28, 8'h82, "R9");
    strobe(4'd5, "R9"); idle(6'h30, "R9");
    wr(6'h28, 8'h02, "R9");

    // randomized mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom;
      logic [5:0] a;
      logic [7:0] d;
      case (r % 5)
        0: a = 6'h28;
        1: a = 6'h30;
        2: a = 6'h38;
        3: a = 6'h38;
        default: a = 6'($urandom);
      endcase
      d = 8'($urandom);
      if (a == 6'h28 && ((r >> 4) % 4 != 0)) d[1] = ~d[7];
      if (a == 6'h30 && ((r >> 6) % 4 != 0)) d[6] = ~d[7];
      step(((r >> 8) % 3) == 0, a, d, ((r >> 10) % 2) == 1, 4'($urandom), "R5");
    end
    idle(6'h28, "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule